// File: doc/BRIEF.md
# Compare-Terminated Byte String Loader

This block copies a string of bytes from memory into a bank of 32-bit registers. The string starts at a given address and holds up to 127 bytes. Bytes arrive one at a time through a byte read port that uses a request/ready handshake. The block packs each byte into the next byte lane of the current register, starting at the most significant lane. It writes the register back through a read-modify-write port, so the lanes it does not touch keep their old contents. When all four lanes of a register are used, the loader moves on to the next register, wrapping from 31 back to 0.

The loader stops early at the first byte that equals a compare byte. It then reports the zero-based position of that byte. If no byte matches, it reports the full byte count. Two register indices can be protected: a register named by either one is never written. The bytes aimed at a protected register are still read, and the lane and register positions still advance past them. A 32-bit addressing mode keeps every byte address inside a 4 GiB window, wrapping at the top of that window.

Top module: `byte_string_loader`

## Requirements
- R1: The first byte goes into bits 31:24 of the starting register. Each later byte goes into the next lane down: bits 23:16, then 15:8, then 7:0.
- R2: After bits 7:0 of a register are filled, the next byte goes into bits 31:24 of the register whose index is one higher, modulo 32.
- R3: Each register write equals the register's previous value with only the one selected byte lane replaced.
- R4: No write is made to the register whose index equals `prot_b`. No write is made to the register whose index equals `prot_a` when `prot_a` is nonzero; when `prot_a` is 0 it protects nothing. A byte aimed at a protected register is still read, and the lane and register still advance.
- R5: After a byte equal to `cmp_byte` has been stored, the loader stops and makes no further reads. `result` is the zero-based index of that byte.
- R6: When no byte matches, the loader stops after `byte_cnt` bytes and `result` equals `byte_cnt`.
- R7: The byte address starts at `start_addr` and rises by 1 for each byte. When `addr_mode32` is 1, every address has its upper bits at zero, and its low 32 bits wrap from 0xFFFFFFFF to 0. When `addr_mode32` is 0, the full 64-bit address carries.
- R8: A start with `byte_cnt` equal to 0 raises `done` in the next cycle with `result` equal to 0, and makes no memory read.
- R9: `mem_req` stays high, with `mem_addr` unchanged, until a cycle in which `mem_ready` is high. The byte on `mem_data` in that cycle is the one consumed, and its register write happens in that same cycle.
- R10: `done` is a single-cycle pulse in the cycle after the final byte is accepted. `result` holds its value until the next run completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted while the loader is idle |
| start_addr | input | 64 | Address of the first byte |
| addr_mode32 | input | 1 | 1 selects 32-bit wrapping addresses |
| byte_cnt | input | 7 | Number of bytes to load (0 to 127) |
| cmp_byte | input | 8 | Byte value that ends the string |
| first_reg | input | 5 | Index of the first destination register |
| prot_a | input | 5 | Protected index; 0 means no protection |
| prot_b | input | 5 | Protected index, always in force |
| mem_req | output | 1 | Byte read request |
| mem_addr | output | 64 | Byte read address |
| mem_ready | input | 1 | Read data valid in this cycle |
| mem_data | input | 8 | Byte read data |
| rf_rd_idx | output | 5 | Register file read index |
| rf_rd_data | input | 32 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_wr_idx | output | 5 | Register file write index |
| rf_wr_data | output | 32 | Register file write data |
| done | output | 1 | Completion pulse |
| result | output | 7 | Number of bytes processed, or the index of the matching byte |

## Verification
Some properties are checked on every cycle. A held request keeps its address. A write changes at most one byte lane and never targets a protected index. Each accepted byte steps the address by one, and in 32-bit mode the upper address bits stay zero. A match stops all requests. A zero count finishes at once, and `done` lasts a single cycle. Other behaviour only the bench scenarios can show, by comparing against a model built from the requirements. These are the lane order, the register wrap from 31 to 0, and which registers end up holding which bytes. They also cover the result value for an early match, a match on the first or last byte, and a run that reaches the full count, as well as the exact address sequence across both address wraps.

// File: rtl/bsl_pkg.sv
package bsl_pkg;

    localparam int DATA_W  = 32;
    localparam int LANES   = DATA_W / 8;
    localparam int LANE_W  = $clog2(LANES);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_FIN   = 2'd2
    } ld_state_t;

    typedef struct packed {
        logic [4:0] idx;
        logic [LANE_W-1:0] lane;
    } cursor_t;

    // One flag per byte lane that differs between two words
    function automatic logic [LANES-1:0] lane_diff(input logic [DATA_W-1:0] a,
                                                   input logic [DATA_W-1:0] b);
        logic [LANES-1:0] d;
        for (int i = 0; i < LANES; i++) begin
            d[i] = (a[8*i +: 8] != b[8*i +: 8]);
        end
        return d;
    endfunction

    function automatic logic idx_guarded(input logic [4:0] idx,
                                         input logic [4:0] pa,
                                         input logic [4:0] pb);
        return (idx == pb) || ((pa != 5'd0) && (idx == pa));
    endfunction

endpackage

// File: rtl/bsl_addr_step.sv
module bsl_addr_step #(
    parameter int AW = 64
) (
    input  logic [AW-1:0] cur,
    input  logic          narrow,
    output logic [AW-1:0] nxt
);
    localparam int HI_W = AW - 32;

    logic [AW-1:0] sum;

    always_comb begin
        sum = cur + AW'(1);
        if (narrow) begin
            nxt = {{HI_W{1'b0}}, sum[31:0]};
        end else begin
            nxt = sum;
        end
    end
endmodule

// File: rtl/bsl_lane_merge.sv
module bsl_lane_merge
    import bsl_pkg::*;
(
    input  logic [DATA_W-1:0] old_word,
    input  logic [7:0]        new_byte,
    input  logic [LANE_W-1:0] lane_sel,
    output logic [DATA_W-1:0] new_word
);
    // lane_sel 0 addresses the most significant byte
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [LANE_W-1:0] POS = LANE_W'(LANES - 1 - g);
        assign new_word[8*g +: 8] = (lane_sel == POS) ? new_byte : old_word[8*g +: 8];
    end
endmodule

// File: rtl/byte_string_loader.sv
module byte_string_loader
    import bsl_pkg::*;
#(
    parameter int AW = 64,
    parameter int CW = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [AW-1:0]     start_addr,
    input  logic              addr_mode32,
    input  logic [CW-1:0]     byte_cnt,
    input  logic [7:0]        cmp_byte,
    input  logic [4:0]        first_reg,
    input  logic [4:0]        prot_a,
    input  logic [4:0]        prot_b,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic              mem_ready,
    input  logic [7:0]        mem_data,
    output logic [4:0]        rf_rd_idx,
    input  logic [DATA_W-1:0] rf_rd_data,
    output logic              rf_we,
    output logic [4:0]        rf_wr_idx,
    output logic [DATA_W-1:0] rf_wr_data,
    output logic              done,
    output logic [CW-1:0]     result
);
    localparam int HI_W = AW - 32;

    ld_state_t         st;
    cursor_t           cur_q;
    logic [AW-1:0]     addr_q;
    logic [AW-1:0]     addr_nxt;
    logic [CW-1:0]     cnt_q;
    logic [CW-1:0]     pos_q;
    logic [CW-1:0]     res_q;
    logic [7:0]        cmp_q;
    logic [4:0]        pa_q;
    logic [4:0]        pb_q;
    logic              m32_q;
    logic              take;
    logic              hit;
    logic              last;
    logic [DATA_W-1:0] merged;
    logic [AW-1:0]     first_addr;

    assign take = (st == ST_FETCH) && mem_ready;
    assign hit  = take && (mem_data == cmp_q);
    assign last = take && (pos_q == CW'(cnt_q - CW'(1)));
    assign first_addr = addr_mode32 ? {{HI_W{1'b0}}, start_addr[31:0]} : start_addr;

    bsl_addr_step #(.AW(AW)) u_step (
        .cur    (addr_q),
        .narrow (m32_q),
        .nxt    (addr_nxt)
    );

    bsl_lane_merge u_merge (
        .old_word (rf_rd_data),
        .new_byte (mem_data),
        .lane_sel (cur_q.lane),
        .new_word (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cur_q  <= '0;
            addr_q <= '0;
            cnt_q  <= '0;
            pos_q  <= '0;
            res_q  <= '0;
            cmp_q  <= '0;
            pa_q   <= '0;
            pb_q   <= '0;
            m32_q  <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        cur_q.idx  <= first_reg;
                        cur_q.lane <= '0;
                        addr_q     <= first_addr;
                        cnt_q      <= byte_cnt;
                        pos_q      <= '0;
                        cmp_q      <= cmp_byte;
                        pa_q       <= prot_a;
                        pb_q       <= prot_b;
                        m32_q      <= addr_mode32;
                        if (byte_cnt == '0) begin
                            res_q <= '0;
                            st    <= ST_FIN;
                        end else begin
                            st    <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: begin
                    if (hit) begin
                        res_q <= pos_q;
                        st    <= ST_FIN;
                    end else if (last) begin
                        res_q <= cnt_q;
                        st    <= ST_FIN;
                    end else if (take) begin
                        pos_q      <= pos_q + CW'(1);
                        addr_q     <= addr_nxt;
                        cur_q.lane <= cur_q.lane + LANE_W'(1);
                        if (cur_q.lane == LANE_W'(LANES - 1)) begin
                            cur_q.idx <= cur_q.idx + 5'd1;
                        end
                    end
                end
                ST_FIN:  st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign mem_req    = (st == ST_FETCH);
    assign mem_addr   = addr_q;
    assign rf_rd_idx  = cur_q.idx;
    assign rf_wr_idx  = cur_q.idx;
    assign rf_we      = take && !idx_guarded(cur_q.idx, pa_q, pb_q);
    assign rf_wr_data = merged;
    assign done       = (st == ST_FIN);
    assign result     = res_q;

    // R9: a pending request keeps its address
    p_req_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

    // R3: at most one byte lane changes on a write
    p_one_lane_r3: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> ($countones(lane_diff(rf_wr_data, rf_rd_data)) <= 1));

    // R4: protected indices are never written
    p_guard_r4: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> ((rf_wr_idx != pb_q) && !((pa_q != 5'd0) && (rf_wr_idx == pa_q))));

    // R7: each accepted byte moves the address up by one
    p_addr_step_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ready && mem_data != cmp_q && !last) |=>
        (mem_addr[31:0] == $past(mem_addr[31:0]) + 32'd1));

    // R7: the upper address bits stay clear in 32-bit mode
    p_addr_narrow_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && m32_q) |-> (mem_addr[AW-1:32] == '0));

    // R5: a matching byte ends the requests
    p_stop_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ready && mem_data == cmp_q) |=> !mem_req);

    // R8: a zero count finishes at once without a read
    p_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && start && byte_cnt == '0) |=> (done && !mem_req && result == '0));

    // R10: done lasts one cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: tb/tb_byte_string_loader.sv
module tb_byte_string_loader;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [63:0] start_addr;
    logic        addr_mode32;
    logic [6:0]  byte_cnt;
    logic [7:0]  cmp_byte;
    logic [4:0]  first_reg, prot_a, prot_b;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_ready;
    logic [7:0]  mem_data;
    logic [4:0]  rf_rd_idx, rf_wr_idx;
    logic [31:0] rf_rd_data, rf_wr_data;
    logic        rf_we, done;
    logic [6:0]  result;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] rf [32];
    logic        do_fill = 1'b0;
    logic [7:0]  fill_seed = 8'd0;
    int          stall_cfg = 0;
    int          stall_left = 0;
    logic [63:0] acc_log [256];
    int          acc_n = 0;

    always #4 clk = ~clk;

    byte_string_loader dut (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .addr_mode32(addr_mode32), .byte_cnt(byte_cnt), .cmp_byte(cmp_byte),
        .first_reg(first_reg), .prot_a(prot_a), .prot_b(prot_b),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready),
        .mem_data(mem_data), .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
        .rf_we(rf_we), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
        .done(done), .result(result)
    );

    function automatic logic [7:0] mem_byte(input logic [63:0] a);
        return a[7:0] ^ 8'hC3;
    endfunction

    function automatic logic [31:0] fillv(input int i, input logic [7:0] s);
        return {8'(i), s, 8'hE0 ^ 8'(i), 8'h1D + s};
    endfunction

    assign rf_rd_data = rf[rf_rd_idx];

    always @(posedge clk) begin
        if (do_fill) begin
            for (int i = 0; i < 32; i++) rf[i] <= fillv(i, fill_seed);
        end else if (rf_we) begin
            rf[rf_wr_idx] <= rf_wr_data;
        end
    end

    // Memory responder with a configurable wait count per byte
    always @(negedge clk) begin
        mem_ready = 1'b0;
        if (mem_req) begin
            if (stall_left > 0) begin
                stall_left = stall_left - 1;
            end else begin
                mem_ready = 1'b1;
                mem_data  = mem_byte(mem_addr);
                acc_log[acc_n % 256] = mem_addr;
                acc_n = acc_n + 1;
                stall_left = stall_cfg;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic run(input string tag, input logic [63:0] a, input logic m32,
                       input int cnt, input logic [7:0] cmp, input logic [4:0] r0,
                       input logic [4:0] pa, input logic [4:0] pb, input int stall,
                       input logic [7:0] seed);
        logic [31:0] er [32];
        logic [63:0] ea [128];
        logic [63:0] ad;
        logic [4:0]  r;
        int          ln, eres, en, base, w, bad_reg;
        @(negedge clk);
        fill_seed = seed;
        do_fill   = 1'b1;
        stall_cfg = stall;
        stall_left = stall;
        @(negedge clk);
        do_fill = 1'b0;
        for (int i = 0; i < 32; i++) er[i] = fillv(i, seed);
        ad = m32 ? {32'd0, a[31:0]} : a;
        r = r0; ln = 0; eres = cnt; en = 0;
        for (int i = 0; i < cnt; i++) begin
            logic [7:0] b;
            b = mem_byte(ad);
            ea[i] = ad;
            en = i + 1;
            if (!(r == pb || (pa != 0 && r == pa))) er[r][8*(3-ln) +: 8] = b;
            if (b == cmp) begin eres = i; break; end
            ad = m32 ? {32'd0, ad[31:0] + 32'd1} : ad + 64'd1;
            if (ln == 3) begin ln = 0; r = r + 5'd1; end else ln = ln + 1;
        end
        base = acc_n;
        start_addr = a; addr_mode32 = m32; byte_cnt = 7'(cnt); cmp_byte = cmp;
        first_reg = r0; prot_a = pa; prot_b = pb;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        w = 0;
        while (!done && w < 4000) begin @(negedge clk); w++; end
        chk(done, tag, "done seen", {63'd0, done}, 64'd1);
        chk(result == 7'(eres), tag, "result", {57'd0, result}, 64'(eres));
        bad_reg = 0;
        for (int i = 0; i < 32; i++) begin
            if (rf[i] !== er[i]) begin
                bad_reg++;
                $display("FAIL %s reg %0d: actual %h expected %h", tag, i, rf[i], er[i]);
            end
        end
        n_chk++;
        if (bad_reg != 0) n_bad++;
        chk(acc_n - base == en, tag, "read count", 64'(acc_n - base), 64'(en));
        for (int i = 0; i < en && i < acc_n - base; i++) begin
            if (acc_log[(base + i) % 256] !== ea[i]) begin
                chk(1'b0, tag, "address", acc_log[(base + i) % 256], ea[i]);
                break;
            end
        end
        @(negedge clk);
        chk(!done, tag, "done single cycle (R10)", {63'd0, done}, 64'd0);
    endtask

    task automatic t_reset;
        chk(!mem_req && !rf_we && !done && result == 0, "R10", "reset outputs",
            {61'd0, mem_req, rf_we, done}, 64'd0);
    endtask

    // R1 R3 R6: lane order, lane preservation, full count
    task automatic t_basic;
        run("R1_R3_R6 basic", 64'h40, 1'b0, 6, 8'h00, 5'd3, 5'd0, 5'd20, 0, 8'h11);
    endtask

    // R5: match in the middle and on the first byte
    task automatic t_match;
        run("R5 mid match", 64'h80, 1'b0, 10, mem_byte(64'h85), 5'd7, 5'd0, 5'd20, 1, 8'h22);
        run("R5 first match", 64'h90, 1'b0, 10, mem_byte(64'h90), 5'd7, 5'd0, 5'd20, 0, 8'h23);
        run("R5 last match", 64'hA0, 1'b0, 20, mem_byte(64'hB3), 5'd1, 5'd0, 5'd30, 0, 8'h24);
    endtask

    // R2: register index wraps 31 -> 0
    task automatic t_regwrap;
        run("R2 reg wrap", 64'h10, 1'b0, 12, 8'hFF ^ 8'hC3 ^ 8'h00, 5'd30, 5'd0, 5'd20, 0, 8'h33);
    endtask

    // R4: both protections, and prot_a of zero protects nothing
    task automatic t_protect;
        run("R4 guarded", 64'h20, 1'b0, 12, 8'h00, 5'd2, 5'd3, 5'd4, 0, 8'h44);
        run("R4 zero pa", 64'h30, 1'b0, 8, 8'h00, 5'd31, 5'd0, 5'd5, 0, 8'h45);
    endtask

    // R8: zero count
    task automatic t_zero;
        int base;
        base = acc_n;
        @(negedge clk);
        byte_cnt = 7'd0; start_addr = 64'h50; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done && result == 0, "R8", "zero count done/result", {56'd0, done, result}, {56'd0, 1'b1, 7'd0});
        repeat (3) @(negedge clk);
        chk(acc_n == base, "R8", "zero count reads", 64'(acc_n - base), 64'd0);
    endtask

    // R7: address wrap in both modes
    task automatic t_addr;
        run("R7 wrap32", 64'h1234_5678_FFFF_FFFE, 1'b1, 4, 8'h55, 5'd9, 5'd0, 5'd20, 0, 8'h55);
        run("R7 carry64", 64'h1234_5678_FFFF_FFFE, 1'b0, 4, 8'h55, 5'd9, 5'd0, 5'd20, 0, 8'h56);
    endtask

    // R9: wait states on the read port
    task automatic t_stall;
        run("R9 stalls", 64'h60, 1'b0, 9, 8'h00, 5'd12, 5'd0, 5'd20, 3, 8'h66);
    endtask

    // R6: maximum count with no match
    task automatic t_full;
        run("R6 full count", 64'h00, 1'b0, 127, mem_byte(64'd200), 5'd0, 5'd0, 5'd31, 0, 8'h77);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; start_addr = '0; addr_mode32 = 1'b0;
        byte_cnt = '0; cmp_byte = '0; first_reg = '0; prot_a = '0; prot_b = '0;
        mem_ready = 1'b0; mem_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_match();
        t_regwrap();
        t_protect();
        t_zero();
        t_addr();
        t_stall();
        t_full();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule